// File: doc/BRIEF.md
# Transport Stream Packet Synchronizer

This block sits on a byte-wide transport stream that arrives with a per-byte valid strobe. It hunts for the 0x47 sync byte that opens a packet. It then counts only the bytes marked valid and checks that the next sync byte falls exactly 188 or exactly 204 valid bytes later. When that happens the block declares lock to that packet length. From then on it checks only that one position.

Every byte and its valid strobe leave the block one clock later, unchanged. Alongside them comes a six-bit status vector whose pulses and lock field line up with the outgoing byte they describe. A missed sync position raises an error pulse, drops lock and sends the block back to the search. A downstream packet parser can use the status vector to frame packets and to discard data while the block is unlocked.

Top module: `ts_sync_top`

## Requirements
- R1: While searching, a valid input byte equal to 0x47 (all 8 bits compared) raises the packet-start pulse on status bit 1 in the output cycle of that byte. Other bytes raise no pulse.
- R2: A cycle with the input valid low gives out_vld low and no pulse on status bits 1 to 3. It changes neither the lock field nor the byte count. Only valid bytes advance the count.
- R3: Before lock, a sync byte at valid-byte distance exactly 188 from the previous sync byte locks to 188. Otherwise, a sync byte at distance exactly 204 locks to 204. A non-sync byte at distance 188 lets the count run on towards 204.
- R4: The lock field on status bits 5:4 is 00 when unlocked, 01 when locked to 188 and 10 when locked to 204. The value 11 never appears. The field shows the state after the byte on the same output cycle.
- R5: A sync byte at the expected position raises the end-of-packet pulse on status bit 2 together with status bit 1, and the lock field is non-zero in that cycle.
- R6: If the byte at the expected position is not 0x47, status bit 3 pulses and the lock field reads 00 in that same cycle. The expected position is the locked length when locked, or 204 when not yet locked.
- R7: After an error the block searches from scratch, and the next valid 0x47 is taken as a fresh packet start.
- R8: While locked, a 0x47 byte at any position before the expected one is ignored. This includes the other candidate length. Such a byte raises no pulse and does not restart the count.
- R9: out_byte and out_vld equal in_byte and in_vld delayed by one clock cycle.
- R10: A synchronous active-high reset clears the count, the lock field, the pulses and out_vld, and returns the block to search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Incoming stream byte |
| in_vld | input | 1 | High when in_byte carries a stream byte |
| out_byte | output | 8 | Stream byte, delayed one cycle |
| out_vld | output | 1 | Valid strobe, delayed one cycle |
| status | output | 6 | Bit 0 reads 0; bit 1 packet start; bit 2 end of packet; bit 3 packet error; bits 5:4 lock field |

## Verification
The assertions assume only that in_vld and in_byte are known values at every clock edge outside reset. They place no limit on how often valid bytes arrive or on what the payload carries. The stimulus therefore lets payload bytes take the sync value now and then. It drops idle cycles holding random data, including 0x47, between valid bytes, and switches between the two packet lengths. It also corrupts the occasional sync byte, so that the lock, end-of-packet and error rules all fire under the same free input conditions. Reset is held for more than one cycle in the stimulus, although the properties tolerate a single-cycle reset.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;

    typedef enum logic [1:0] {
        ST_SEEK  = 2'd0,
        ST_TRACK = 2'd1,
        ST_LOCK  = 2'd2
    } sync_state_e;

    localparam logic [1:0] LOCK_NONE  = 2'b00;
    localparam logic [1:0] LOCK_SHORT = 2'b01;
    localparam logic [1:0] LOCK_LONG  = 2'b10;

    localparam int STAT_W   = 6;
    localparam int STAT_SOP = 1;
    localparam int STAT_EOP = 2;
    localparam int STAT_ERR = 3;
    localparam int STAT_LK0 = 4;

endpackage

// File: rtl/ts_sync_match.sv
module ts_sync_match #(
    parameter int          DW       = 8,
    parameter logic [7:0]  SYNC_VAL = 8'h47
) (
    input  logic [DW-1:0] byte_i,
    output logic          hit_o
);
    localparam logic [DW-1:0] PATTERN = DW'(SYNC_VAL);

    always_comb begin
        hit_o = (byte_i == PATTERN);
    end
endmodule

// File: rtl/ts_sync_fsm.sv
module ts_sync_fsm
    import ts_sync_pkg::*;
#(
    parameter int LEN_A = 188,
    parameter int LEN_B = 204
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vld_i,
    input  logic       hit_i,
    output logic       sop_o,
    output logic       eop_o,
    output logic       err_o,
    output logic [1:0] lock_o
);
    localparam int CW = $clog2(LEN_B + 1);
    localparam logic [CW-1:0] POS_A = CW'(LEN_A);
    localparam logic [CW-1:0] POS_B = CW'(LEN_B);

    typedef struct packed {
        sync_state_e   st;
        logic          long_len;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic [CW-1:0] pos;
    logic [CW-1:0] want;

    always_comb begin
        nxt_d = cur_q;
        sop_o = 1'b0;
        eop_o = 1'b0;
        err_o = 1'b0;
        pos   = cur_q.cnt + CW'(1);
        want  = cur_q.long_len ? POS_B : POS_A;
        if (vld_i) begin
            case (cur_q.st)
                ST_SEEK: begin
                    if (hit_i) begin
                        sop_o     = 1'b1;
                        nxt_d.st  = ST_TRACK;
                        nxt_d.cnt = '0;
                    end
                end
                ST_TRACK: begin
                    if (hit_i && pos == POS_A) begin
                        sop_o          = 1'b1;
                        eop_o          = 1'b1;
                        nxt_d.st       = ST_LOCK;
                        nxt_d.long_len = 1'b0;
                        nxt_d.cnt      = '0;
                    end else if (pos == POS_B) begin
                        nxt_d.cnt = '0;
                        if (hit_i) begin
                            sop_o          = 1'b1;
                            eop_o          = 1'b1;
                            nxt_d.st       = ST_LOCK;
                            nxt_d.long_len = 1'b1;
                        end else begin
                            err_o    = 1'b1;
                            nxt_d.st = ST_SEEK;
                        end
                    end else begin
                        nxt_d.cnt = pos;
                    end
                end
                ST_LOCK: begin
                    if (pos == want) begin
                        nxt_d.cnt = '0;
                        if (hit_i) begin
                            sop_o = 1'b1;
                            eop_o = 1'b1;
                        end else begin
                            err_o          = 1'b1;
                            nxt_d.st       = ST_SEEK;
                            nxt_d.long_len = 1'b0;
                        end
                    end else begin
                        nxt_d.cnt = pos;
                    end
                end
                default: begin
                    nxt_d.st  = ST_SEEK;
                    nxt_d.cnt = '0;
                end
            endcase
        end
        if (nxt_d.st == ST_LOCK) begin
            lock_o = nxt_d.long_len ? LOCK_LONG : LOCK_SHORT;
        end else begin
            lock_o = LOCK_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st       <= ST_SEEK;
            cur_q.long_len <= 1'b0;
            cur_q.cnt      <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/ts_sync_outreg.sv
module ts_sync_outreg
    import ts_sync_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     byte_i,
    input  logic              vld_i,
    input  logic              sop_i,
    input  logic              eop_i,
    input  logic              err_i,
    input  logic [1:0]        lock_i,
    output logic [DW-1:0]     byte_o,
    output logic              vld_o,
    output logic [STAT_W-1:0] stat_o
);
    typedef struct packed {
        logic [DW-1:0]     data;
        logic              vld;
        logic [STAT_W-1:0] stat;
    } out_t;

    out_t out_q, out_d;

    always_comb begin
        out_d.data                     = byte_i;
        out_d.vld                      = vld_i;
        out_d.stat                     = '0;
        out_d.stat[STAT_SOP]           = sop_i;
        out_d.stat[STAT_EOP]           = eop_i;
        out_d.stat[STAT_ERR]           = err_i;
        out_d.stat[STAT_LK0+1:STAT_LK0] = lock_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign byte_o = out_q.data;
    assign vld_o  = out_q.vld;
    assign stat_o = out_q.stat;
endmodule

// File: rtl/ts_sync_top.sv
module ts_sync_top #(
    parameter int         DW       = 8,
    parameter int         LEN_A    = 188,
    parameter int         LEN_B    = 204,
    parameter logic [7:0] SYNC_VAL = 8'h47
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] in_byte,
    input  logic          in_vld,
    output logic [DW-1:0] out_byte,
    output logic          out_vld,
    output logic [5:0]    status
);
    logic       hit;
    logic       sop, eop, err;
    logic [1:0] lock_nxt;

    ts_sync_match #(.DW(DW), .SYNC_VAL(SYNC_VAL)) u_match (
        .byte_i (in_byte),
        .hit_o  (hit)
    );

    ts_sync_fsm #(.LEN_A(LEN_A), .LEN_B(LEN_B)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (in_vld),
        .hit_i  (hit),
        .sop_o  (sop),
        .eop_o  (eop),
        .err_o  (err),
        .lock_o (lock_nxt)
    );

    ts_sync_outreg #(.DW(DW)) u_out (
        .clk    (clk),
        .rst    (rst),
        .byte_i (in_byte),
        .vld_i  (in_vld),
        .sop_i  (sop),
        .eop_i  (eop),
        .err_i  (err),
        .lock_i (lock_nxt),
        .byte_o (out_byte),
        .vld_o  (out_vld),
        .stat_o (status)
    );
endmodule

// File: rtl/ts_sync_chk.sv
module ts_sync_chk #(
    parameter int         DW       = 8,
    parameter logic [7:0] SYNC_VAL = 8'h47
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] in_byte,
    input logic          in_vld,
    input logic [DW-1:0] out_byte,
    input logic          out_vld,
    input logic [5:0]    status
);
    localparam logic [DW-1:0] PATTERN = DW'(SYNC_VAL);

    a_r9_passthru: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (out_vld && out_byte == $past(in_byte)));

    a_r2_idle_cycle: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && status[3:1] == 3'b000
                     && status[5:4] == $past(status[5:4])));

    a_r1_start_is_sync: assert property (@(posedge clk) disable iff (rst)
        status[1] |-> (out_vld && out_byte == PATTERN));

    a_r4_no_reserved_code: assert property (@(posedge clk) disable iff (rst)
        status[5:4] != 2'b11);

    a_r5_eop_with_start: assert property (@(posedge clk) disable iff (rst)
        status[2] |-> (status[1] && status[5:4] != 2'b00));

    a_r6_err_unlocks: assert property (@(posedge clk) disable iff (rst)
        status[3] |-> (out_vld && status[5:4] == 2'b00 && !status[1]));

    a_r3_lock_needs_eop: assert property (@(posedge clk) disable iff (rst)
        (status[5:4] != 2'b00 && $past(status[5:4]) == 2'b00) |-> status[2]);

    a_r7_unlock_needs_err: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(status[5:4]) != 2'b00
         && status[5:4] != $past(status[5:4])) |-> status[3]);
endmodule

bind ts_sync_top ts_sync_chk #(.DW(DW), .SYNC_VAL(SYNC_VAL)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_byte  (in_byte),
    .in_vld   (in_vld),
    .out_byte (out_byte),
    .out_vld  (out_vld),
    .status   (status)
);

// File: tb/sim_ts_sync_top.sv
`timescale 1ns/1ps
module sim_ts_sync_top;
    localparam logic [7:0] SYNC = 8'h47;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_byte = 8'h00;
    logic       in_vld = 1'b0;
    logic [7:0] out_byte;
    logic       out_vld;
    logic [5:0] status;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference state
    int m_st = 0;
    int m_len = 0;
    int m_cnt = 0;
    int m_lock = 0;
    bit have_exp = 0;
    int e_vld, e_byte, e_sop, e_eop, e_err, e_lock;

    always #4 clk = ~clk;

    ts_sync_top u0 (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_vld(in_vld),
        .out_byte(out_byte), .out_vld(out_vld), .status(status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic [7:0] b, input bit v);
        int p;
        e_vld = v; e_byte = b; e_sop = 0; e_eop = 0; e_err = 0;
        if (v) begin
            p = m_cnt + 1;
            if (m_st == 0) begin
                if (b == SYNC) begin e_sop = 1; m_st = 1; m_cnt = 0; end
            end else if (m_st == 1) begin
                if (p == 188 && b == SYNC) begin
                    e_sop = 1; e_eop = 1; m_st = 2; m_len = 188; m_cnt = 0; m_lock = 1;
                end else if (p == 204) begin
                    m_cnt = 0;
                    if (b == SYNC) begin
                        e_sop = 1; e_eop = 1; m_st = 2; m_len = 204; m_lock = 2;
                    end else begin
                        e_err = 1; m_st = 0; m_lock = 0;
                    end
                end else m_cnt = p;
            end else begin
                if (p == m_len) begin
                    m_cnt = 0;
                    if (b == SYNC) begin e_sop = 1; e_eop = 1; end
                    else begin e_err = 1; m_st = 0; m_lock = 0; end
                end else m_cnt = p;
            end
        end
        e_lock = m_lock;
    endtask

    task automatic compare_pending();
        if (have_exp) begin
            chk("R2 out_vld", out_vld, e_vld);
            if (e_vld != 0) chk("R9 out_byte", out_byte, e_byte);
            chk("R1 start pulse", status[1], e_sop);
            chk("R5 end pulse", status[2], e_eop);
            chk("R6 error pulse", status[3], e_err);
            chk("R3 lock field", status[5:4], e_lock);
            chk("R4 reserved code", int'(status[5:4] == 2'b11), 0);
            chk("status bit0", status[0], 0);
        end
    endtask

    task automatic step(input logic [7:0] b, input bit v);
        @(negedge clk);
        compare_pending();
        in_byte = b;
        in_vld  = v;
        model_step(b, v);
        have_exp = 1;
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        compare_pending();
        rst = 1; in_vld = 0; in_byte = 8'h00;
        have_exp = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk("R10 vld in reset", out_vld, 0);
            chk("R10 status in reset", status, 0);
        end
        rst = 0;
        m_st = 0; m_cnt = 0; m_len = 0; m_lock = 0;
        e_vld = 0; e_byte = 0; e_sop = 0; e_eop = 0; e_err = 0; e_lock = 0;
        have_exp = 1;
    endtask

    function automatic logic [7:0] filler();
        logic [7:0] b = 8'($urandom);
        if (b == SYNC) b = 8'h48;
        return b;
    endfunction

    // sends payload positions 1..n; position 'mark' carries 0x47
    task automatic payload(input int n, input int mark, input bit gaps);
        for (int i = 1; i <= n; i++) begin
            if (gaps && ($urandom % 8) == 0) step(($urandom % 2) ? SYNC : filler(), 0);
            step((i == mark) ? SYNC : filler(), 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        do_reset(3);

        // R1: non-sync bytes give no start, then a sync byte does
        step(8'h46, 1); step(8'hC7, 1); step(8'h47, 0);
        step(SYNC, 1);
        step(8'h00, 0);
        chk("R1 sync starts packet", status[1], 1);
        chk("R1 still unlocked", status[5:4], 0);

        // R3 lock at 188, embedded 0x47 and idle gaps in payload
        payload(187, 50, 1);
        step(SYNC, 1);
        step(8'h00, 0);
        chk("R3 lock to 188", status[5:4], 1);
        chk("R5 eop on lock", status[2], 1);

        // R8: locked, 0x47 inside payload ignored
        payload(99, 0, 0);
        step(SYNC, 1);
        step(8'h00, 0);
        chk("R8 payload sync ignored", status[1], 0);
        chk("R8 lock kept", status[5:4], 1);
        payload(87, 0, 0);
        step(SYNC, 1);
        step(8'h00, 0);
        chk("R8 count not restarted", status[2], 1);

        // R6: missing sync at 188
        payload(187, 0, 0);
        step(8'h11, 1);
        step(8'h00, 0);
        chk("R6 error raised", status[3], 1);
        chk("R6 lock dropped", status[5:4], 0);

        // R7: fresh search right after error
        step(SYNC, 1);
        step(8'h00, 0);
        chk("R7 new start after error", status[1], 1);

        // R3: lock at 204 (non-sync at 188)
        payload(203, 0, 1);
        step(SYNC, 1);
        step(8'h00, 0);
        chk("R3 lock to 204", status[5:4], 2);

        // R8: locked 204, sync at 188 position ignored
        payload(187, 0, 0);
        step(SYNC, 1);
        step(8'h00, 0);
        chk("R8 other length ignored", status[2], 0);
        chk("R8 lock stays 204", status[5:4], 2);
        payload(15, 0, 0);
        step(SYNC, 1);
        step(8'h00, 0);
        chk("R5 eop at 204", status[2], 1);

        // R10: reset mid-lock
        payload(100, 0, 0);
        do_reset(2);
        step(SYNC, 1);
        step(8'h00, 0);
        chk("R10 search after reset", status[1], 1);
        chk("R10 lock cleared", status[5:4], 0);
        payload(187, 0, 0);
        step(SYNC, 1);

        // random traffic
        for (int k = 0; k < 48; k++) begin
            int len;
            bit bad;
            len = ((k / 6) % 2 == 0) ? 188 : 204;
            bad = (($urandom % 9) == 0);
            step(bad ? filler() : SYNC, 1);
            for (int i = 1; i < len; i++) begin
                if (($urandom % 10) == 0) step(8'($urandom), 0);
                step((($urandom % 20) == 0) ? SYNC : filler(), 1);
            end
        end
        step(8'h00, 0);
        step(8'h00, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule